// File: doc/BRIEF.md
# Row-Sequenced Scan Clock Controller

This controller drives a scan array whose flip-flops are split into rows, each row with its own scan enable and scan clock. Row stimuli arrive in parallel on a shared bus, so only one row may accept data in a given tester cycle. While test enable is high the controller steps through the rows in a fixed order, one row per tester cycle. It then runs one capture cycle in which every scan enable is low and every scan clock pulses together. The next round follows at once, so the unload of one pattern overlaps the load of the next.

The enable and counter registers change on the falling edge of the tester clock. Each row's scan clock is the high phase of the tester clock, passed through a latch-based gate that is controlled by that row's enable. A row's enable therefore leads its clock edge by half a tester period. A capture indicator marks the capture cycle so the tester can apply primary inputs during it. While test enable is low, or while reset is held, every row clock follows the functional clock unchanged.

Top module: `row_scan_ctl`

## Requirements
- R1: While `rst` is high at a falling edge of `tclk`, that edge leaves every `row_en` bit and `capture` low. The design then returns to functional mode, in which `row_clk` follows `func_clk`.
- R2: At no time is more than one `row_en` bit high.
- R3: The first falling edge of `tclk` with `test_en` high sets `row_en` to bit 0. Each later falling edge moves the single high bit from bit i to bit i+1, so every enable pulse lasts one full `tclk` period.
- R4: In a load cycle, `row_clk[i]` is high only during the high phase of `tclk` while `row_en[i]` is high. It rises half a period after `row_en[i]` rises, stays high for half a period, and is low during the whole low phase.
- R5: The falling edge after row ROWS-1 starts one capture cycle. In it `capture` is 1, all `row_en` bits are 0, and every `row_clk` bit pulses during the high phase of `tclk`.
- R6: After a capture cycle the next falling edge starts row 0 again, so every round lasts ROWS+1 cycles. Counting from the first active edge, the first p*(ROWS+1)+ROWS cycles contain exactly p captures and (p+1)*ROWS row enables.
- R7: While `test_en` is low, every `row_clk` bit equals `func_clk`, and `row_en` and `capture` stay low.
- R8: If `test_en` falls in the middle of a round, the next falling edge clears all enables and gives the row clocks back to `func_clk`. When `test_en` rises again, or when a reset ends in the middle of a round, the sequence restarts at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Tester clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | High selects the scan sequence, low selects the functional clock |
| func_clk | input | 1 | Functional clock passed to the rows outside test |
| row_en | output | ROWS | Per-row scan enable, at most one high |
| row_clk | output | ROWS | Per-row clock: gated tester clock in test, functional clock otherwise |
| capture | output | 1 | High during the all-rows capture cycle |

## Verification
Two things fall in the same cycle. The last row must finish loading, and that same cycle's falling edge must start the capture that pulses every row clock at once. Three instances with 4, 3 and 1 rows run from one stimulus. In every cycle the bench checks both phases of `tclk` against a position computed as cycle modulo ROWS+1. The one-row instance is the hardest case: there the load and capture cycles strictly alternate. The bench also drops test enable and asserts reset in the middle of a round, and then checks that the sequence restarts at row 0.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LOAD    = 2'd1,
    PH_CAPTURE = 2'd2
  } seq_phase_e;
endpackage

// File: rtl/row_sequencer.sv
module row_sequencer
  import row_scan_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic            tclk,
  input  logic            rst,
  input  logic            test_en,
  output logic [ROWS-1:0] row_en,
  output logic [ROWS-1:0] gate_en,
  output logic            mode,
  output logic            capture
);
  localparam int CW = $clog2(ROWS + 1);

  seq_phase_e      phase_q;
  logic [CW-1:0]   nxt_q;
  logic [ROWS-1:0] en_q;

  always_ff @(negedge tclk) begin
    if (rst || !test_en) begin
      phase_q <= PH_IDLE;
      nxt_q   <= '0;
      en_q    <= '0;
    end else if (phase_q == PH_LOAD && en_q[ROWS-1]) begin
      phase_q <= PH_CAPTURE;
      nxt_q   <= '0;
      en_q    <= '0;
    end else begin
      phase_q <= PH_LOAD;
      en_q    <= ROWS'(1) << nxt_q;
      nxt_q   <= nxt_q + CW'(1);
    end
  end

  assign row_en  = en_q;
  assign capture = (phase_q == PH_CAPTURE);
  assign mode    = (phase_q != PH_IDLE);
  assign gate_en = capture ? '1 : en_q;

  // R2: single active row
  assert_one_row_R2: assert property (@(negedge tclk) disable iff (rst)
    $onehot0(row_en));

  // R5: no row enable during capture
  assert_capture_quiet_R5: assert property (@(negedge tclk) disable iff (rst)
    capture |-> (row_en == '0));

  // R3: the active row advances by one each cycle
  assert_row_order_R3: assert property (@(negedge tclk) disable iff (rst || !test_en)
    (row_en != '0 && !row_en[ROWS-1]) |=> (row_en == ($past(row_en) << 1)));

  // R5: last row is followed by capture
  assert_last_to_capture_R5: assert property (@(negedge tclk) disable iff (rst || !test_en)
    row_en[ROWS-1] |=> capture);

  // R6: capture is followed by row 0
  assert_wrap_R6: assert property (@(negedge tclk) disable iff (rst || !test_en)
    capture |=> (row_en == ROWS'(1)));
endmodule

// File: rtl/row_clk_gate.sv
module row_clk_gate (
  input  logic tclk,
  input  logic rst,
  input  logic func_clk,
  input  logic mode,
  input  logic gate_en,
  output logic row_clk
);
  logic gate_q;

  // transparent while tclk is low, so the enable is frozen during the high phase
  always_latch begin
    if (!tclk) gate_q <= gate_en;
  end

  assign row_clk = mode ? (tclk & gate_q) : func_clk;

  // R4: a scan clock high phase only occurs inside its enable
  assert_clk_within_en_R4: assert property (@(negedge tclk) disable iff (rst)
    (mode && row_clk) |-> gate_en);
endmodule

// File: rtl/row_scan_ctl.sv
module row_scan_ctl #(
  parameter int ROWS = 4
) (
  input  logic            tclk,
  input  logic            rst,
  input  logic            test_en,
  input  logic            func_clk,
  output logic [ROWS-1:0] row_en,
  output logic [ROWS-1:0] row_clk,
  output logic            capture
);
  logic [ROWS-1:0] gate_en;
  logic            mode;

  row_sequencer #(.ROWS(ROWS)) u_seq (
    .tclk    (tclk),
    .rst     (rst),
    .test_en (test_en),
    .row_en  (row_en),
    .gate_en (gate_en),
    .mode    (mode),
    .capture (capture)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    row_clk_gate u_gate (
      .tclk     (tclk),
      .rst      (rst),
      .func_clk (func_clk),
      .mode     (mode),
      .gate_en  (gate_en[g]),
      .row_clk  (row_clk[g])
    );
  end
endmodule

// File: tb/sim_row_scan_ctl.sv
module sim_row_scan_ctl;
  localparam int CLK_HALF = 10;
  localparam int NI = 3;
  localparam int PATS = 3;

  logic tclk = 1'b0;
  logic fclk = 1'b0;
  logic rst = 1'b1;
  logic test_en = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #CLK_HALF tclk = ~tclk;
  initial begin
    #1;
    forever #4 fclk = ~fclk;
  end

  logic [3:0] en0, ck0;
  logic [2:0] en1, ck1;
  logic [0:0] en2, ck2;
  logic       cp0, cp1, cp2;

  row_scan_ctl #(.ROWS(4)) u0 (.tclk(tclk), .rst(rst), .test_en(test_en), .func_clk(fclk),
    .row_en(en0), .row_clk(ck0), .capture(cp0));
  row_scan_ctl #(.ROWS(3)) u1 (.tclk(tclk), .rst(rst), .test_en(test_en), .func_clk(fclk),
    .row_en(en1), .row_clk(ck1), .capture(cp1));
  row_scan_ctl #(.ROWS(1)) u2 (.tclk(tclk), .rst(rst), .test_en(test_en), .func_clk(fclk),
    .row_en(en2), .row_clk(ck2), .capture(cp2));

  int unsigned rows_of [NI] = '{4, 3, 1};
  logic [7:0] en_a [NI];
  logic [7:0] ck_a [NI];
  logic       cp_a [NI];
  assign en_a[0] = 8'(en0);
  assign en_a[1] = 8'(en1);
  assign en_a[2] = 8'(en2);
  assign ck_a[0] = 8'(ck0);
  assign ck_a[1] = 8'(ck1);
  assign ck_a[2] = 8'(ck2);
  assign cp_a[0] = cp0;
  assign cp_a[1] = cp1;
  assign cp_a[2] = cp2;

  int caps [NI];
  int loads [NI];

  task automatic chk(input string req, input int inst, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s u%0d %s actual=%b expected=%b", req, inst, what, got, exp);
    end
  endtask

  // one tester cycle: sample at falling edge +3 (low phase) and +14 (high phase)
  task automatic step(input bit active, input int k, input string req);
    logic [7:0] mask, exp_en, exp_hi;
    logic       exp_cp;
    @(negedge tclk);
    #3;
    for (int i = 0; i < NI; i++) begin
      int unsigned m = rows_of[i];
      int unsigned ph = (k < 0) ? 0 : (k % (m + 1));
      mask = 8'((1 << m) - 1);
      if (active) begin
        exp_en = (ph < m) ? (8'd1 << ph) : 8'd0;
        exp_cp = (ph == m);
        exp_hi = (ph < m) ? exp_en : mask;
        if (k < PATS * (m + 1) + m) begin
          if (exp_cp) caps[i]++;
          if (en_a[i] != 0) loads[i]++;
        end
        chk(req, i, "row_en", en_a[i], exp_en);
        chk(exp_cp ? "R5" : req, i, "capture", {7'd0, cp_a[i]}, {7'd0, exp_cp});
        chk("R4", i, "row_clk low phase", ck_a[i], 8'd0);
      end else begin
        chk(req, i, "row_en idle", en_a[i], 8'd0);
        chk(req, i, "capture idle", {7'd0, cp_a[i]}, 8'd0);
        chk("R7", i, "row_clk bypass", ck_a[i], {8{fclk}} & mask);
      end
    end
    #11;
    for (int i = 0; i < NI; i++) begin
      int unsigned m = rows_of[i];
      int unsigned ph = (k < 0) ? 0 : (k % (m + 1));
      mask = 8'((1 << m) - 1);
      if (active) begin
        exp_hi = (ph < m) ? (8'd1 << ph) : mask;
        chk((ph == m) ? "R5" : "R4", i, "row_clk high phase", ck_a[i], exp_hi);
      end else begin
        chk("R7", i, "row_clk bypass high", ck_a[i], {8{fclk}} & mask);
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int i = 0; i < NI; i++) begin
      caps[i] = 0;
      loads[i] = 0;
    end
    // R1: reset holds everything idle
    step(0, -1, "R1");
    step(0, -1, "R1");
    rst = 1'b0;
    // R7: functional clock passes through
    for (int k = 0; k < 3; k++) step(0, -1, "R7");
    // R3/R5/R6: long run of rounds
    test_en = 1'b1;
    for (int k = 0; k < 40; k++) step(1, k, "R3");
    for (int i = 0; i < NI; i++) begin
      chk("R6", i, "capture count", 8'(caps[i]), 8'(PATS));
      chk("R6", i, "row enable count", 8'(loads[i]), 8'((PATS + 1) * rows_of[i]));
    end
    // R8: drop test enable mid-round, then restart from row 0
    test_en = 1'b0;
    step(0, -1, "R8");
    step(0, -1, "R8");
    test_en = 1'b1;
    for (int k = 0; k < 7; k++) step(1, k, "R8");
    // R1/R8: reset in the middle of a round, then restart
    rst = 1'b1;
    step(0, -1, "R1");
    rst = 1'b0;
    for (int k = 0; k < 6; k++) step(1, k, "R8");
    summary();
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end
endmodule